// File: doc/BRIEF.md
# Serial Control Port for a Four-Channel Digital Potentiometer

This block is the serial host port of a multi-channel digital potentiometer controller. A bus master selects it by pulling `cs_n` low and clocks bytes in on `si`, most significant bit first. The first byte of each frame is an 8-bit device address. The second byte is an instruction that names a channel, one of that channel's registers, and a direction. Any further bytes are data. On a write they are stored into the register file. On a read they are shifted out on `so`. The register index steps to the next register after every data byte.

The block runs on the chip's system clock. It samples `sck`, `cs_n`, `hold_n` and `si` as synchronous inputs and finds serial clock edges by comparing each sample with the one before. The tri-state serial output is presented as a data bit and an enable for the pad cell. Register 0 of each channel is the volatile wiper position and is brought out on `wiper`. Registers 1 to 3 are nonvolatile data registers. Each permitted write to one of them raises a one-cycle request pulse carrying the channel, the register index and the data byte. Several of these ports can share one bus, because each one answers only to the address set by its strap pins.

Top module: `spi_pot_port`

## Requirements
- R1: A bit on `si` is taken on each rising `sck` edge while the frame is active. Bytes are assembled most significant bit first.
- R2: During a read, `so` changes only on falling `sck` edges. The first falling edge after the instruction byte presents bit 7 of the addressed register. After the 8th bit, the next register follows.
- R3: `so_oe` is low whenever `cs_n` is high, and also in the address phase, the instruction phase, write frames and frames with a rejected address. It is low after reset.
- R4: After reset, the port accepts no frame until `cs_n` has gone from high to low once. A frame sent while `cs_n` has stayed low since reset changes nothing.
- R5: If `hold_n` is low while `sck` is low, the transfer pauses. During the pause, `sck` edges are ignored, the partial byte and the frame position are kept, and `so_oe` is low. The pause ends when `hold_n` is high while `sck` is low.
- R6: A change of `hold_n` that starts and ends while `sck` is high has no effect on the transfer.
- R7: The address byte is accepted only if bits 7:2 equal 6'b010100 and bits 1:0 equal `strap`. If it is rejected, the rest of the frame is ignored.
- R8: Instruction byte layout: bit 7 is 1 for read and 0 for write, bits 3:2 select the channel, and bits 1:0 select the register. Bits 6:4 are ignored. Register 0 is volatile and registers 1 to 3 are nonvolatile.
- R9: While `wp_n` is low, a data byte written to register 1, 2 or 3 is discarded and raises no request. Writes to register 0 and all reads still take effect.
- R10: Each accepted write to register 1, 2 or 3 raises `nv_wr` for exactly one clock. In that clock, `nv_ch`, `nv_reg` and `nv_data` carry the target and the byte.
- R11: If `cs_n` goes high at any point, the frame ends and the bit count is cleared. A byte left incomplete updates nothing, and the next frame starts again with an address byte.
- R12: Each further data byte in a frame moves to the next register of the same channel. The index wraps from 3 to 0. This applies to both reads and writes.
- R13: `wiper[8c+7:8c]` shows register 0 of channel c. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| sck | input | 1 | Serial clock, sampled on `clk` |
| cs_n | input | 1 | Select, active low |
| hold_n | input | 1 | Pause request, active low, accepted only while `sck` is low |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Nonvolatile write protect, active low |
| strap | input | 2 | Low two bits of the device address |
| so | output | 1 | Serial data out, valid when `so_oe` is high |
| so_oe | output | 1 | Output enable for the serial data pad |
| wiper | output | 32 | Register 0 of each channel, channel 0 in the low byte |
| nv_wr | output | 1 | One-cycle nonvolatile write request |
| nv_ch | output | 2 | Channel of the request |
| nv_reg | output | 2 | Register index of the request |
| nv_data | output | 8 | Data byte of the request |

## Verification
Some rules are checked on every cycle. `so` may move only on a sampled falling edge of `sck`. A paused frame must keep its bit count and partial byte. Before arming, nothing is written and no request is raised. A request is never wider than one clock, never targets register 0, and never follows a cycle in which `wp_n` was low.

Other behaviour depends on a whole sequence of bytes and can only be shown by the bench's scenarios. These cover the address comparison against the strap pins and the device-type bits, the discarding of a truncated byte, the wrap of the register index within a channel, and read data coming back intact after a pause.

// File: rtl/spi_pot_port.sv
module spi_pot_port #(
  parameter int CHANNELS = 4,
  parameter int REGS = 4,
  parameter logic [5:0] DEV_TYPE = 6'b010100,
  localparam int CW = $clog2(CHANNELS),
  localparam int RW = $clog2(REGS),
  localparam int WW = CHANNELS * 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          hold_n,
  input  logic          si,
  input  logic          wp_n,
  input  logic [1:0]    strap,
  output logic          so,
  output logic          so_oe,
  output logic [WW-1:0] wiper,
  output logic          nv_wr,
  output logic [CW-1:0] nv_ch,
  output logic [RW-1:0] nv_reg,
  output logic [7:0]    nv_data
);

  typedef enum logic [1:0] {PH_ADDR, PH_INSTR, PH_DATA, PH_SKIP} phase_t;

  phase_t        phase;
  logic          sck_q, cs_q, armed, paused, rd, so_bit, so_en;
  logic [2:0]    bitcnt, obit;
  logic [7:0]    shreg, out_sr;
  logic [CW-1:0] ch;
  logic [RW-1:0] ptr;
  logic [7:0]    regs [CHANNELS*REGS];

  wire          active    = armed & ~cs_n & ~paused;
  wire          rise      = active & sck & ~sck_q;
  wire          fall      = active & ~sck & sck_q;
  wire [7:0]    rx_byte   = {shreg[6:0], si};
  wire          byte_done = rise & (bitcnt == 3'd7);
  wire [RW-1:0] ptr_nx    = ptr + 1'b1;
  wire [CW-1:0] ins_ch    = rx_byte[RW+CW-1:RW];
  wire [RW-1:0] ins_reg   = rx_byte[RW-1:0];
  wire          wr_ok     = byte_done & (phase == PH_DATA) & ~rd & ((ptr == '0) | wp_n);
  wire          nv_go     = wr_ok & (ptr != '0);
  wire          addr_hit  = (rx_byte[7:2] == DEV_TYPE) & (rx_byte[1:0] == strap);

  assign so    = so_bit;
  assign so_oe = ~cs_n & ~paused & so_en;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_wiper
    assign wiper[c*8 +: 8] = regs[c*REGS];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < CHANNELS*REGS; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      regs[{ch, ptr}] <= rx_byte;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase   <= PH_ADDR;
      sck_q   <= 1'b0;
      cs_q    <= 1'b0;
      armed   <= 1'b0;
      paused  <= 1'b0;
      rd      <= 1'b0;
      so_bit  <= 1'b0;
      so_en   <= 1'b0;
      bitcnt  <= '0;
      obit    <= '0;
      shreg   <= '0;
      out_sr  <= '0;
      ch      <= '0;
      ptr     <= '0;
      nv_wr   <= 1'b0;
      nv_ch   <= '0;
      nv_reg  <= '0;
      nv_data <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      nv_wr <= 1'b0;
      if (cs_q & ~cs_n) armed <= 1'b1;
      if (cs_n) begin
        phase  <= PH_ADDR;
        paused <= 1'b0;
        bitcnt <= '0;
        obit   <= '0;
        so_en  <= 1'b0;
      end else begin
        if (~sck) paused <= ~hold_n;
        if (rise) begin
          shreg  <= rx_byte;
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          case (phase)
            PH_ADDR:  phase <= addr_hit ? PH_INSTR : PH_SKIP;
            PH_INSTR: begin
              phase  <= PH_DATA;
              rd     <= rx_byte[7];
              ch     <= ins_ch;
              ptr    <= ins_reg;
              out_sr <= regs[{ins_ch, ins_reg}];
            end
            PH_DATA:  if (~rd) ptr <= ptr_nx;
            default: ;
          endcase
        end
        if (nv_go) begin
          nv_wr   <= 1'b1;
          nv_ch   <= ch;
          nv_reg  <= ptr;
          nv_data <= rx_byte;
        end
        if (fall && phase == PH_DATA && rd) begin
          so_bit <= out_sr[7];
          so_en  <= 1'b1;
          obit   <= obit + 3'd1;
          if (obit == 3'd7) begin
            out_sr <= regs[{ch, ptr_nx}];
            ptr    <= ptr_nx;
          end else begin
            out_sr <= {out_sr[6:0], 1'b0};
          end
        end
      end
    end
  end

endmodule

module spi_pot_port_chk #(
  parameter int RW = 2,
  parameter int WW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cs_n,
  input logic          sck,
  input logic          wp_n,
  input logic          so_oe,
  input logic          nv_wr,
  input logic [RW-1:0] nv_reg,
  input logic [WW-1:0] wiper,
  input logic          armed,
  input logic          paused,
  input logic          sck_q,
  input logic          so_bit,
  input logic [2:0]    bitcnt,
  input logic [7:0]    shreg
);

  AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(so_bit) |-> ($past(sck_q) && !$past(sck))); // R2

  AST_SO_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> (armed && $past(!cs_n))); // R3

  AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(armed) |-> ($stable(wiper) && !nv_wr)); // R4

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    ($past(paused) && !$past(cs_n)) |-> ($stable(bitcnt) && $stable(shreg))); // R5

  AST_NV_TARGET: assert property (@(posedge clk) disable iff (rst)
    nv_wr |-> (nv_reg != '0)); // R8

  AST_NV_WP_GATE: assert property (@(posedge clk) disable iff (rst)
    nv_wr |-> $past(wp_n)); // R9

  AST_NV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    nv_wr |=> !nv_wr); // R10

endmodule

bind spi_pot_port spi_pot_port_chk #(.RW(RW), .WW(WW)) u_chk (.*);

// File: tb/spi_pot_port_tb_top.sv
`timescale 1ns/1ps
module spi_pot_port_tb_top;

  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] ADR   = 8'h52;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b0, hold_n = 1'b1, si = 1'b0, wp_n = 1'b1;
  logic so, so_oe, nv_wr;
  logic [31:0] wiper;
  logic [1:0] nv_ch, nv_reg;
  logic [7:0] nv_data;

  int checks = 0, errors = 0, nv_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_pot_port dut_i (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
    .wp_n(wp_n), .strap(STRAP), .so(so), .so_oe(so_oe), .wiper(wiper),
    .nv_wr(nv_wr), .nv_ch(nv_ch), .nv_reg(nv_reg), .nv_data(nv_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced once per clock
  int m_sckq, m_csq, m_armed, m_paused, m_bits, m_acc, m_stage;
  int m_rd, m_ch, m_ptr, m_out, m_obit, m_sobit, m_soen;
  int m_regs[16];
  int e_nv, e_nvch, e_nvreg, e_nvdata;

  always @(posedge clk) begin
    if (rst) begin
      m_sckq = 0; m_csq = 0; m_armed = 0; m_paused = 0; m_bits = 0; m_acc = 0;
      m_stage = 0; m_rd = 0; m_ch = 0; m_ptr = 0; m_out = 0; m_obit = 0;
      m_sobit = 0; m_soen = 0; e_nv = 0; e_nvch = 0; e_nvreg = 0; e_nvdata = 0;
      foreach (m_regs[i]) m_regs[i] = 0;
    end else begin
      int act, up, dn, b, np, na;
      act = m_armed && !cs_n && !m_paused;
      up  = act && sck && !m_sckq;
      dn  = act && !sck && m_sckq;
      na  = m_armed || (m_csq && !cs_n);
      e_nv = 0;
      if (cs_n) begin
        m_paused = 0; m_stage = 0; m_bits = 0; m_obit = 0; m_soen = 0;
      end else begin
        np = sck ? m_paused : !hold_n;
        if (up) begin
          m_acc = ((m_acc << 1) | si) & 255;
          m_bits++;
          if (m_bits == 8) begin
            m_bits = 0;
            b = m_acc;
            case (m_stage)
              0: m_stage = ((b >> 2) == 6'h14 && (b & 3) == STRAP) ? 1 : 3;
              1: begin
                m_rd = b >> 7; m_ch = (b >> 2) & 3; m_ptr = b & 3;
                m_out = m_regs[m_ch*4 + m_ptr]; m_stage = 2;
              end
              2: if (!m_rd) begin
                if (m_ptr == 0 || wp_n) m_regs[m_ch*4 + m_ptr] = b;
                if (m_ptr != 0 && wp_n) begin
                  e_nv = 1; e_nvch = m_ch; e_nvreg = m_ptr; e_nvdata = b;
                end
                m_ptr = (m_ptr + 1) & 3;
              end
              default: ;
            endcase
          end
        end
        if (dn && m_stage == 2 && m_rd) begin
          m_sobit = (m_out >> 7) & 1;
          m_soen = 1;
          if (m_obit == 7) begin
            m_obit = 0; m_ptr = (m_ptr + 1) & 3; m_out = m_regs[m_ch*4 + m_ptr];
          end else begin
            m_obit++; m_out = (m_out << 1) & 255;
          end
        end
        m_paused = np;
      end
      m_armed = na; m_sckq = sck; m_csq = cs_n;
    end
  end

  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      int eoe;
      eoe = (!cs_n && !m_paused && m_soen) ? 1 : 0;
      chk(so_oe == eoe, "R3 so_oe", so_oe, eoe);
      if (eoe) chk(so == m_sobit, "R2 so", so, m_sobit);
      for (int c = 0; c < 4; c++) chk(wiper[c*8 +: 8] == m_regs[c*4], "R13 wiper", wiper[c*8 +: 8], m_regs[c*4]);
      chk(nv_wr == e_nv, "R10 nv_wr", nv_wr, e_nv);
      if (e_nv) begin
        chk(nv_ch == e_nvch && nv_reg == e_nvreg, "R10 nv target", {nv_ch, nv_reg}, e_nvch*4 + e_nvreg);
        chk(nv_data == e_nvdata, "R10 nv_data", nv_data, e_nvdata);
      end
      if (nv_wr) nv_cnt++;
    end
  end

  task automatic xbyte(input logic [7:0] tx, input int nb, input int pbit, input int pmode,
                       output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i >= 8 - nb; i--) begin
      @(negedge clk); si = tx[i];
      repeat (2) @(negedge clk);
      if (i == pbit && pmode == 1) begin
        hold_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(so_oe == 1'b0, "R5 so_oe during pause", so_oe, 0);
        repeat (2) begin
          sck = 1'b1; repeat (3) @(negedge clk);
          sck = 1'b0; repeat (3) @(negedge clk);
        end
        hold_n = 1'b1;
        repeat (3) @(negedge clk);
      end
      rx[i] = so;
      sck = 1'b1;
      repeat (2) @(negedge clk);
      if (i == pbit && pmode == 2) begin
        hold_n = 1'b0; @(negedge clk); hold_n = 1'b1;
      end
      @(negedge clk); sck = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0; repeat (3) @(negedge clk);
  endtask

  task automatic desel();
    @(negedge clk); cs_n = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic wr2(input logic [7:0] a, input logic [7:0] ins, input logic [7:0] d);
    logic [7:0] r;
    sel(); xbyte(a, 8, -1, 0, r); xbyte(ins, 8, -1, 0, r); xbyte(d, 8, -1, 0, r); desel();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1;
    int nv0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(so_oe == 1'b0, "R3 reset so_oe", so_oe, 0);
    chk(wiper == 32'h0, "R13 reset wiper", wiper, 0);

    // R4: cs_n low since reset, no falling edge yet
    xbyte(ADR, 8, -1, 0, r0); xbyte(8'h04, 8, -1, 0, r0); xbyte(8'h5A, 8, -1, 0, r0);
    chk(wiper[15:8] == 8'h00, "R4 unarmed write", wiper[15:8], 0);
    desel();

    // R1: volatile write, channel 1 register 0
    wr2(ADR, 8'h04, 8'hA5);
    chk(wiper[15:8] == 8'hA5, "R1 write", wiper[15:8], 8'hA5);

    // R2 R8: read it back
    sel(); xbyte(ADR, 8, -1, 0, r0); xbyte(8'h84, 8, -1, 0, r0);
    chk(so_oe == 1'b1, "R3 so_oe in read data", so_oe, 1);
    xbyte(8'h00, 8, -1, 0, r0); desel();
    chk(r0 == 8'hA5, "R2 read back", r0, 8'hA5);

    // R12 R10: write channel 2 register 3 then wrap into register 0
    nv0 = nv_cnt;
    sel(); xbyte(ADR, 8, -1, 0, r0); xbyte(8'h0B, 8, -1, 0, r0);
    xbyte(8'h11, 8, -1, 0, r0); xbyte(8'h22, 8, -1, 0, r0); desel();
    chk(wiper[23:16] == 8'h22, "R12 write wrap", wiper[23:16], 8'h22);
    chk(nv_cnt - nv0 == 1, "R10 request count", nv_cnt - nv0, 1);

    sel(); xbyte(ADR, 8, -1, 0, r0); xbyte(8'h8B, 8, -1, 0, r0);
    xbyte(8'h00, 8, -1, 0, r0); xbyte(8'h00, 8, -1, 0, r1); desel();
    chk(r0 == 8'h11, "R12 read first", r0, 8'h11);
    chk(r1 == 8'h22, "R12 read wrapped", r1, 8'h22);

    // R9: write protect
    wp_n = 1'b0;
    nv0 = nv_cnt;
    wr2(ADR, 8'h09, 8'h77);
    wr2(ADR, 8'h00, 8'h3C);
    chk(wiper[7:0] == 8'h3C, "R9 volatile allowed", wiper[7:0], 8'h3C);
    chk(nv_cnt == nv0, "R9 no request", nv_cnt - nv0, 0);
    sel(); xbyte(ADR, 8, -1, 0, r0); xbyte(8'h89, 8, -1, 0, r0); xbyte(8'h00, 8, -1, 0, r0); desel();
    chk(r0 == 8'h00, "R9 protected register", r0, 0);
    wp_n = 1'b1;

    // R7: address mismatches
    wr2(8'h53, 8'h00, 8'h99);
    chk(wiper[7:0] == 8'h3C, "R7 strap mismatch", wiper[7:0], 8'h3C);
    wr2(8'hD2, 8'h00, 8'h99);
    chk(wiper[7:0] == 8'h3C, "R7 type mismatch", wiper[7:0], 8'h3C);
    sel(); xbyte(8'h50, 8, -1, 0, r0); xbyte(8'h80, 8, -1, 0, r0); xbyte(8'h00, 8, -1, 0, r0);
    chk(so_oe == 1'b0, "R7 no output on mismatch", so_oe, 0);
    desel();

    // R11: abort a partial byte, then a clean frame
    sel(); xbyte(ADR, 8, -1, 0, r0); xbyte(8'h00, 8, -1, 0, r0); xbyte(8'hFF, 5, -1, 0, r0); desel();
    chk(wiper[7:0] == 8'h3C, "R11 partial discarded", wiper[7:0], 8'h3C);
    wr2(ADR, 8'h00, 8'h81);
    chk(wiper[7:0] == 8'h81, "R11 next frame clean", wiper[7:0], 8'h81);

    // R5: pause mid-byte in a write and in a read
    sel(); xbyte(ADR, 8, -1, 0, r0); xbyte(8'h04, 8, 3, 1, r0); xbyte(8'h6E, 8, 4, 1, r0); desel();
    chk(wiper[15:8] == 8'h6E, "R5 write across pause", wiper[15:8], 8'h6E);
    sel(); xbyte(ADR, 8, -1, 0, r0); xbyte(8'h84, 8, -1, 0, r0); xbyte(8'h00, 8, 2, 1, r0); desel();
    chk(r0 == 8'h6E, "R5 read across pause", r0, 8'h6E);

    // R6: hold pulse while sck high has no effect
    sel(); xbyte(ADR, 8, -1, 0, r0); xbyte(8'h0C, 8, -1, 0, r0); xbyte(8'hC3, 8, 5, 2, r0); desel();
    chk(wiper[31:24] == 8'hC3, "R6 glitch ignored", wiper[31:24], 8'hC3);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule